// File: doc/BRIEF.md
# PWM Clock-Enable Prescaler with Scaled Clock

This block makes the per-channel count enables for a four-channel pulse-width timer. Its only timebase is a system enable pulse, `e_en`, which marks the ticks of the bus clock. It builds three enables from that pulse, and none of them is a derived clock. Clock A divides the E ticks by 1, 2, 4 or 8. Clock B divides them by any power of two from 1 to 128. Clock S counts clock A ticks against a programmable scale value, then halves the resulting match rate.

A small write port holds the configuration: the two rate selects, the scale value, and one source bit per channel. Channels 0 and 1 each pick either clock A or clock S. Channels 2 and 3 each pick either clock B or clock S. Each channel output is a registered single-cycle enable for the timer counter that follows. Any write to the scale value restarts the S match counter from zero. Because of this, lowering the scale never lets the counter run past the new limit and wrap through its full range.

Top module: `pwm_clk_prescaler`

## Requirements
- R1: When `rst` is high, every `ch_en` bit is low. Reset clears all configuration to zero: clock A and clock B run at the E rate, every channel uses its base clock, and the scale value reads as zero, which means 256. Reset also clears both dividers, the match counter and the halving toggle.
- R2: A `ch_en` bit is high only in the cycle directly after a cycle in which `e_en` was high. The channel path is one register deep.
- R3: Address 0, bits [1:0] = k selects clock A as one tick every 2^k E ticks (k = 0..3).
- R4: Address 0, bits [6:4] = k selects clock B as one tick every 2^k E ticks (k = 0..7).
- R5: Address 1 holds the scale value N, where 0 stands for 256. A match fires on every N-th clock A tick. Clock S fires on every second match, which gives one S tick per 2·N clock A ticks.
- R6: A write to address 1 clears the match counter at that edge. With clock A at the E rate and `e_en` held high, writing N = 3 just after an S tick makes the next S-sourced `ch_en` pulse appear exactly 7 cycles after the write cycle. From then on, S-sourced pulses come every 6 E ticks.
- R7: Address 2, bit i selects the source of channel i. A value of 1 selects clock S. A value of 0 selects the base clock, which is clock A for channels 0 and 1 and clock B for channels 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| e_en | input | 1 | E-clock tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 rates, 1 scale, 2 sources) |
| wr_data | input | 8 | Register write data |
| ch_en | output | 4 | Per-channel count enable pulses |

## Verification
Every channel pulse shows up one cycle after the E tick that causes it. Because of this, the monitor measures spacing as a count of E ticks between pulses, counting the tick that produces a pulse against the interval that pulse closes. This makes the spacing check independent of gaps in `e_en`. After a configuration write, the bench waits two cycles so that the one pulse from the old setting still in the output register drains out. It then throws away the first interval after arming, since that interval straddles the change. The scale-restart case is timed in raw cycles from the write cycle: two match-counter passes of three ticks each, plus the output register, put the pulse 7 cycles after the write.

// File: rtl/pwmpre_pkg.sv
package pwmpre_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NCH     = 4;
    localparam int A_SEL_W = 2;
    localparam int B_SEL_W = 3;
    localparam int SCALE_W = 8;

    // bit offsets of the rate selects inside the rate register
    localparam int A_LO = 0;
    localparam int B_LO = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_RATE  = 2'd0,
        REG_SCALE = 2'd1,
        REG_SRC   = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [A_SEL_W-1:0] a_sel;
        logic [B_SEL_W-1:0] b_sel;
        logic [SCALE_W-1:0] scale;
        logic [NCH-1:0]     src;
    } pwm_cfg_t;

    // channels in the lower half take clock A as their base, the rest clock B
    function automatic bit base_is_a(int idx);
        return idx < (NCH / 2);
    endfunction

endpackage

// File: rtl/pwmpre_regs.sv
module pwmpre_regs
    import pwmpre_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output pwm_cfg_t          cfg,
    output logic              scale_wr
);

    reg_addr_e addr;

    assign addr     = reg_addr_e'(wr_addr);
    assign scale_wr = wr_en && (addr == REG_SCALE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_RATE: begin
                    cfg.a_sel <= wr_data[A_LO +: A_SEL_W];
                    cfg.b_sel <= wr_data[B_LO +: B_SEL_W];
                end
                REG_SCALE: cfg.scale <= wr_data[SCALE_W-1:0];
                REG_SRC:   cfg.src   <= wr_data[NCH-1:0];
                default:   ;
            endcase
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg)); // R7

endmodule

// File: rtl/pwmpre_pow2div.sv
module pwmpre_pow2div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             e_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    // low sel bits set; a shift by the full width wraps to all ones
    assign mask = (CNT_W'(1) << sel) - CNT_W'(1);
    assign tick = e_en && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (e_en) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !e_en |=> $stable(cnt)); // R3

endmodule

// File: rtl/pwmpre_scaler.sv
module pwmpre_scaler #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_tick,
    input  logic             scale_wr,
    input  logic [CNT_W-1:0] scale,
    output logic             s_tick
);

    localparam int LIM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic             tog;
    logic [LIM_W-1:0] limit;
    logic             match;

    // a scale of zero stands for the full 2**CNT_W count
    assign limit  = (scale == '0) ? (LIM_W'(1) << CNT_W) : {1'b0, scale};
    assign match  = a_tick && ({1'b0, cnt} == (limit - LIM_W'(1)));
    assign s_tick = match && tog && !scale_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            tog <= 1'b0;
        end else if (scale_wr) begin
            cnt <= '0;
        end else if (match) begin
            cnt <= '0;
            tog <= ~tog;
        end else if (a_tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_SCNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        scale_wr |=> (cnt == '0)); // R6

    AST_SCNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt} < limit)); // R5

    AST_TOG_AFTER_S: assert property (@(posedge clk) disable iff (rst)
        s_tick |=> !tog); // R5

endmodule

// File: rtl/pwm_clk_prescaler.sv
module pwm_clk_prescaler
    import pwmpre_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              e_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCH-1:0]    ch_en
);

    pwm_cfg_t       cfg;
    logic           scale_wr;
    logic           a_tick;
    logic           b_tick;
    logic           s_tick;
    logic [NCH-1:0] pick;

    pwmpre_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg      (cfg),
        .scale_wr (scale_wr)
    );

    pwmpre_pow2div #(.SEL_W(A_SEL_W)) u_div_a (
        .clk  (clk),
        .rst  (rst),
        .e_en (e_en),
        .sel  (cfg.a_sel),
        .tick (a_tick)
    );

    pwmpre_pow2div #(.SEL_W(B_SEL_W)) u_div_b (
        .clk  (clk),
        .rst  (rst),
        .e_en (e_en),
        .sel  (cfg.b_sel),
        .tick (b_tick)
    );

    pwmpre_scaler #(.CNT_W(SCALE_W)) u_scaler (
        .clk      (clk),
        .rst      (rst),
        .a_tick   (a_tick),
        .scale_wr (scale_wr),
        .scale    (cfg.scale),
        .s_tick   (s_tick)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        if (base_is_a(gi)) begin : g_a
            assign pick[gi] = cfg.src[gi] ? s_tick : a_tick;
        end else begin : g_b
            assign pick[gi] = cfg.src[gi] ? s_tick : b_tick;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_en <= '0;
        end else begin
            ch_en <= pick;
        end
    end

    AST_PULSE_NEEDS_E: assert property (@(posedge clk) disable iff (rst)
        (ch_en != '0) |-> $past(e_en)); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (ch_en == '0)); // R1

endmodule

// File: tb/sim_pwm_clk_prescaler.sv
module sim_pwm_clk_prescaler;
    import pwmpre_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              e_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [NCH-1:0]    ch_en;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_clk_prescaler u0 (
        .clk     (clk),
        .rst     (rst),
        .e_en    (e_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ch_en   (ch_en)
    );

    typedef struct {
        int    ch;
        int    exp;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    armed = 1'b0;
    int    gap_cnt = 0;
    int    e_mode = 0;
    int    e_phase = 0;
    bit    r2_bad = 1'b0;
    bit    done = 1'b0;

    // monitor: E ticks between pulses, then E tick generator
    always @(negedge clk) begin
        if (!rst) begin
            if ((ch_en != '0) && !e_en) r2_bad = 1'b1;
            if (e_en) gap_cnt++;
            if (exp_q.size() != 0) begin
                if (ch_en[exp_q[0].ch]) begin
                    if (armed) begin
                        item_t it;
                        it = exp_q.pop_front();
                        checks++;
                        if (gap_cnt != it.exp) begin
                            errors++;
                            $display("FAIL %s ch%0d period got %0d expected %0d",
                                     it.tag, it.ch, gap_cnt, it.exp);
                        end
                        armed = (exp_q.size() != 0) && (exp_q[0].ch == it.ch);
                    end else begin
                        armed = 1'b1;
                    end
                    gap_cnt = 0;
                end
            end else begin
                armed = 1'b0;
            end
        end
        e_phase = (e_phase + 1) % 3;
        e_en = (e_mode == 0) ? 1'b1 : (e_phase == 0);
    end

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_data = DATA_W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic expect_per(input int ch, input int exp, input string tag);
        exp_q.push_back('{ch, exp, tag});
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired with %0d items pending", exp_q.size());
            summary();
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet while reset is held
        repeat (3) @(negedge clk);
        chk(ch_en == '0, "R1 ch_en in reset", int'(ch_en), 0);
        rst = 1'b0;

        // R1: defaults give E rate on every channel
        settle();
        for (int c = 0; c < NCH; c++) expect_per(c, 1, "R1 default rate");
        drain();

        // R1 R5: reset scale reads as 256, so S on ch0 is A/512
        wr(2, 1);
        settle();
        expect_per(0, 512, "R1 default scale");
        drain();
        wr(2, 0);

        // R3: clock A rates on channels 0 and 1
        for (int k = 0; k < 4; k++) begin
            wr(0, k);
            settle();
            expect_per(0, 1 << k, "R3 clock A");
            expect_per(1, 1 << k, "R3 clock A");
            drain();
        end

        // R4: clock B rates on channels 2 and 3
        for (int k = 0; k < 8; k++) begin
            wr(0, k << 4);
            settle();
            expect_per(2, 1 << k, "R4 clock B");
            expect_per(3, 1 << k, "R4 clock B");
            expect_per(3, 1 << k, "R4 clock B");
            drain();
        end

        // R5 R7: mixed sources, scale 1, A/2, B/32
        wr(0, (5 << 4) | 1);
        wr(1, 1);
        wr(2, 4'b0101);
        settle();
        expect_per(0, 4, "R5 S with N=1");
        expect_per(2, 4, "R7 ch2 on S");
        expect_per(1, 2, "R7 ch1 on A");
        expect_per(3, 32, "R7 ch3 on B");
        drain();

        // R5: scale 5 with A/4
        wr(0, 2);
        wr(1, 5);
        settle();
        expect_per(0, 40, "R5 S with N=5");
        drain();

        // R5: scale 0 (256) with A/8 on ch3
        wr(0, 3);
        wr(1, 0);
        wr(2, 4'b1000);
        settle();
        expect_per(3, 4096, "R5 S with N=256");
        expect_per(2, 1, "R7 ch2 back on B");
        drain();

        // R5: scale 255 with A at E rate on ch1
        wr(0, 0);
        wr(1, 255);
        wr(2, 4'b0010);
        settle();
        expect_per(1, 510, "R5 S with N=255");
        drain();

        // R2 R3 R4 R5: E ticks with gaps
        e_mode = 1;
        wr(0, (3 << 4) | 2);
        wr(1, 3);
        wr(2, 4'b0100);
        settle();
        expect_per(0, 4, "R3 gapped E");
        expect_per(2, 24, "R5 gapped E");
        expect_per(3, 8, "R4 gapped E");
        drain();
        e_mode = 0;

        // R6: lowering the scale mid-count restarts the match counter
        wr(0, 0);
        wr(1, 200);
        wr(2, 1);
        do @(negedge clk); while (!ch_en[0]);
        repeat (4) @(negedge clk);
        wr(1, 3);
        begin
            int n;
            n = 1;
            while (!ch_en[0] && n < 50) begin
                @(negedge clk);
                n++;
            end
            chk(n == 7, "R6 first S pulse after scale write", n, 7);
        end
        expect_per(0, 6, "R6 rate after scale write");
        expect_per(0, 6, "R6 rate after scale write");
        drain();

        // R2: no pulse was ever seen without its E tick
        chk(!r2_bad, "R2 pulse follows E tick", int'(r2_bad), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule